// File: doc/BRIEF.md
# Square-Wave Interval Timer Channel

This block is one channel of an interval timer. It counts down from a programmed 16-bit reload value in steps of two, reloads when the count is used up, and flips a square-wave output on every reload, so that one full output period lasts exactly `reload` input ticks. The tick is a clock enable, typically pulsed at about 1.193 MHz (a period of roughly 838 ns).

Software reaches the channel through two byte-wide ports that share one write strobe: a control port (`wrCtl` high) and a data port (`wrCtl` low). A control byte either programs the channel (byte-access pattern and counting mode) or takes a snapshot of the running count. Data writes load the reload value one byte at a time. Data reads return the live count or the snapshot, one byte per read. Only the square-wave counting mode runs; the other modes are stored but never count, and BCD counting is not supported.

Top module: `sqwave_timer`

## Requirements
- R1: After reset `sqOut` is high, the channel is not counting, the byte pattern is low-then-high (access 3), and reading the data port twice returns 0x00 and 0x00.
- R2: A control byte acts only when bits 7:6 equal the channel number `CHAN_ID` (default 0). Any other selector, including 3, changes nothing: the count and `sqOut` stay as they were.
- R3: A programming byte (bits 5:4 not 00) stores access (bits 5:4) and mode (bits 3:1), stops counting, clears the count and reload to 0, resets both byte pointers to the first byte of the pattern, and drives `sqOut` high on the next cycle.
- R4: Access 1 touches only the low byte; access 2 touches only the high byte; access 3 alternates low byte then high byte, with separate pointers for data writes and data reads. A read returns its byte in `rdData` one cycle after `rdEn`, with `rdValid` high in that cycle.
- R5: In square-wave mode (mode field 3 or 7) counting starts on the data write that completes the reload: the high-byte write for access 3, the single write for access 1 or 2. The count is loaded from the reload value in that cycle. Later data writes change only the reload.
- R6: While counting, each cycle with `tickEn` high lowers the count by 2; without `tickEn` the count holds.
- R7: When a tick meets a count of 2 or less, the count reloads with the reload value minus the shortfall and `sqOut` toggles. With `ODD_WRAP`=1 two consecutive half-periods always add up to exactly `reload` ticks, for even and odd values.
- R8: A reload value of 0 or 1 acts as 65536: the count after loading plus one tick reads 65534 (0xFE, 0xFF), and the output period is 65536 ticks.
- R9: A latch byte (bits 5:4 = 00) copies the count as it stood before that clock edge. The next two reads return the snapshot low byte then high byte, after which reads follow the access pattern from its first byte. Counting continues during the latch.
- R10: With a mode field other than 3 or 7, data writes update the reload only; the count stays 0 and `sqOut` stays high under ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counting tick enable |
| wrEn | input | 1 | Write strobe |
| wrCtl | input | 1 | 1 selects the control port, 0 the data port |
| wrData | input | 8 | Written byte |
| rdEn | input | 1 | Data-port read strobe |
| rdData | output | 8 | Byte read, valid with `rdValid` |
| rdValid | output | 1 | High the cycle after `rdEn` |
| sqOut | output | 1 | Registered square-wave output |

## Verification
The latch command and a wrap of the count can land on the same clock edge. The bench programs a reload of 10, lets four ticks bring the count to 2, and then writes the latch byte in the fifth tick cycle. The snapshot must read back as 2, the live count as 10, and `sqOut` must have toggled, which shows the snapshot sees the pre-edge count while the wrap still goes ahead.

// File: rtl/sqtimer_pkg.sv
package sqtimer_pkg;

  // Which byte a data-port read returns
  typedef enum logic [1:0] {
    RD_LO     = 2'd0,
    RD_HI     = 2'd1,
    RD_LAT_LO = 2'd2,
    RD_LAT_HI = 2'd3
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   progCtl;   // programming byte accepted
    logic   latchCmd;  // snapshot the count
    logic   wrLo;      // data byte goes to reload low
    logic   wrHi;      // data byte goes to reload high
    logic   armStart;  // reload complete in square-wave mode
    logic   rdStb;     // data-port read
    rdSel_e rdSel;     // byte chosen for that read
  } ctlStb_t;

endpackage

// File: rtl/sqwave_timer_ctrl.sv
module sqwave_timer_ctrl
  import sqtimer_pkg::*;
#(
  parameter int CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrCtl,
  input  logic [7:0] wrData,
  input  logic       rdEn,
  output ctlStb_t    stb
);

  logic [1:0] accQ;
  logic [2:0] modeQ;
  logic       wrHiQ;
  rdSel_e     rdStateQ;

  logic ctlHit, isLatch, isProg, dataWr, isSquare;
  logic unusedBcd;

  assign unusedBcd = wrData[0];
  assign ctlHit    = wrEn && wrCtl && (wrData[7:6] == 2'(CHAN_ID));
  assign isLatch   = ctlHit && (wrData[5:4] == 2'd0);
  assign isProg    = ctlHit && (wrData[5:4] != 2'd0);
  assign dataWr    = wrEn && !wrCtl;
  assign isSquare  = (modeQ == 3'd3) || (modeQ == 3'd7);

  function automatic rdSel_e firstRd(input logic [1:0] acc);
    return (acc == 2'd2) ? RD_HI : RD_LO;
  endfunction

  always_comb begin
    stb          = '0;
    stb.progCtl  = isProg;
    stb.latchCmd = isLatch;
    stb.wrLo     = dataWr && !wrHiQ;
    stb.wrHi     = dataWr && wrHiQ;
    stb.armStart = dataWr && isSquare && ((accQ != 2'd3) || wrHiQ);
    stb.rdStb    = rdEn;
    stb.rdSel    = rdStateQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ     <= 2'd3;
      modeQ    <= 3'd0;
      wrHiQ    <= 1'b0;
      rdStateQ <= RD_LO;
    end else begin
      if (isProg) begin
        accQ  <= wrData[5:4];
        modeQ <= wrData[3:1];
        wrHiQ <= (wrData[5:4] == 2'd2);
      end else if (dataWr && accQ == 2'd3) begin
        wrHiQ <= !wrHiQ;
      end

      if (isProg) begin
        rdStateQ <= firstRd(wrData[5:4]);
      end else if (isLatch) begin
        rdStateQ <= RD_LAT_LO;
      end else if (rdEn) begin
        case (rdStateQ)
          RD_LAT_LO: rdStateQ <= RD_LAT_HI;
          RD_LAT_HI: rdStateQ <= firstRd(accQ);
          RD_LO:     rdStateQ <= (accQ == 2'd3) ? RD_HI : RD_LO;
          default:   rdStateQ <= (accQ == 2'd3) ? RD_LO : RD_HI;
        endcase
      end
    end
  end

  // R9
  latch_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdStateQ == RD_LAT_LO && !ctlHit) |=> rdStateQ == RD_LAT_HI);

  // R4
  low_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accQ == 2'd1 && !isProg) |=> !wrHiQ);

endmodule

// File: rtl/sqwave_timer_dp.sv
module sqwave_timer_dp
  import sqtimer_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int ODD_WRAP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  ctlStb_t           stb,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid,
  output logic              sqOut
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
  localparam logic [CNT_W:0] TWO  = (CNT_W + 1)'(2);

  logic [CNT_W-1:0] reloadQ, latchQ, relNext;
  logic [CNT_W:0]   cntQ, effRaw, eff, cntNext;
  logic             runQ, sqQ, tick, wrapHit;
  logic [BYTE_W-1:0] rdDataQ;
  logic             rdValidQ;

  always_comb begin
    relNext = reloadQ;
    if (stb.wrLo) relNext[BYTE_W-1:0]     = wrData;
    if (stb.wrHi) relNext[CNT_W-1:BYTE_W] = wrData;
  end

  assign effRaw = (relNext <= CNT_W'(1)) ? FULL : {1'b0, relNext};

  generate
    if (ODD_WRAP != 0) begin : g_oddWrap
      assign eff = effRaw;
    end else begin : g_evenOnly
      assign eff = {effRaw[CNT_W:1], 1'b0};
    end
  endgenerate

  assign tick = tickEn && runQ;

  always_comb begin
    if (cntQ > TWO) begin
      cntNext = cntQ - TWO;
      wrapHit = 1'b0;
    end else begin
      cntNext = eff - (TWO - cntQ);
      wrapHit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
      cntQ    <= '0;
      runQ    <= 1'b0;
      sqQ     <= 1'b1;
      latchQ  <= '0;
    end else begin
      if (stb.latchCmd) latchQ <= cntQ[CNT_W-1:0];
      if (stb.progCtl) begin
        reloadQ <= '0;
        cntQ    <= '0;
        runQ    <= 1'b0;
        sqQ     <= 1'b1;
      end else begin
        reloadQ <= relNext;
        if (stb.armStart && !runQ) begin
          cntQ <= eff;
          runQ <= 1'b1;
        end else if (tick) begin
          cntQ <= cntNext;
          if (wrapHit) sqQ <= !sqQ;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= stb.rdStb;
      if (stb.rdStb) begin
        case (stb.rdSel)
          RD_LO:     rdDataQ <= cntQ[BYTE_W-1:0];
          RD_HI:     rdDataQ <= cntQ[CNT_W-1:BYTE_W];
          RD_LAT_LO: rdDataQ <= latchQ[BYTE_W-1:0];
          default:   rdDataQ <= latchQ[CNT_W-1:BYTE_W];
        endcase
      end
    end
  end

  assign rdData  = rdDataQ;
  assign rdValid = rdValidQ;
  assign sqOut   = sqQ;

  // R3
  prog_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.progCtl |=> (sqQ && !runQ && cntQ == '0));

  // R6
  step_by_two_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && cntQ > TWO && !stb.progCtl) |=> cntQ == $past(cntQ) - TWO);

  // R7
  toggle_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sqQ) |-> $past(tick || stb.progCtl));

  // R8
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    runQ |-> (cntQ != '0 && cntQ <= FULL));

endmodule

// File: rtl/sqwave_timer.sv
module sqwave_timer
  import sqtimer_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int CHAN_ID  = 0,
  parameter int ODD_WRAP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              wrCtl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output logic [BYTE_W-1:0] rdData,
  output logic              rdValid,
  output logic              sqOut
);

  ctlStb_t stb;

  sqwave_timer_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrCtl  (wrCtl),
    .wrData (wrData[7:0]),
    .rdEn   (rdEn),
    .stb    (stb)
  );

  sqwave_timer_dp #(.BYTE_W(BYTE_W), .ODD_WRAP(ODD_WRAP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .stb     (stb),
    .wrData  (wrData),
    .rdData  (rdData),
    .rdValid (rdValid),
    .sqOut   (sqOut)
  );

endmodule

// File: tb/sqwave_timer_test.sv
module sqwave_timer_test;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic       wrCtl = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       rdValid;
  logic       sqOut;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  logic lastSq = 1'b1;
  int togT[$];
  logic [7:0] expQ[$];
  string tagQ[$];

  always #(CLK_P/2) clk = ~clk;

  sqwave_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrCtl(wrCtl),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid), .sqOut(sqOut)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Monitor: read results against the scoreboard
  always @(negedge clk) begin
    if (rdValid) begin
      if (expQ.size() == 0) chk(1'b0, "R4 unexpected read data", rdData, 0);
      else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        chk(rdData == e, t, rdData, e);
      end
    end
  end

  // Monitor: output toggle times
  always @(negedge clk) begin
    cyc++;
    if (rstN && sqOut != lastSq) togT.push_back(cyc);
    lastSq = sqOut;
  end

  task automatic ctlWr(input logic [7:0] b);
    wrEn = 1'b1; wrCtl = 1'b1; wrData = b;
    @(negedge clk);
    wrEn = 1'b0; wrCtl = 1'b0;
  endtask

  task automatic dataWr(input logic [7:0] b);
    wrEn = 1'b1; wrCtl = 1'b0; wrData = b;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic period(input logic [15:0] rel, input int expP, input string tag);
    int guard;
    tickEn = 1'b0;
    ctlWr(8'h36);
    tickEn = 1'b1;
    dataWr(rel[7:0]);
    dataWr(rel[15:8]);
    togT.delete();
    guard = 0;
    while (togT.size() < 3 && guard < 140000) begin
      @(negedge clk);
      guard++;
    end
    tickEn = 1'b0;
    if (togT.size() < 3) chk(1'b0, tag, togT.size(), 3);
    else chk(togT[2] - togT[0] == expP, tag, togT[2] - togT[0], expP);
  endtask

  initial begin
    #(CLK_P * 190000);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sqOut == 1'b1, "R1 sqOut after reset", sqOut, 1);
    rd(8'h00, "R1 count low after reset");
    rd(8'h00, "R1 count high after reset");

    // R5 / R4: access 3, counting starts only after the high byte
    ctlWr(8'h36);
    dataWr(8'h10);
    rd(8'h00, "R5 not started low");
    rd(8'h00, "R5 not started high");
    dataWr(8'h02);
    rd(8'h10, "R5 loaded low");
    rd(8'h02, "R5 loaded high");

    // R6 step by two, hold without ticks
    ticks(5);
    repeat (3) @(negedge clk);
    rd(8'h06, "R6 after five ticks low");
    rd(8'h02, "R6 after five ticks high");

    // R2 foreign selectors ignored
    ctlWr(8'hF6);
    ctlWr(8'h76);
    rd(8'h06, "R2 count kept low");
    rd(8'h02, "R2 count kept high");
    chk(sqOut == 1'b1, "R2 sqOut kept", sqOut, 1);

    // R9 latch, counting continues
    ctlWr(8'h00);
    ticks(3);
    rd(8'h06, "R9 latched low");
    rd(8'h02, "R9 latched high");
    rd(8'h00, "R9 live low after latch");
    rd(8'h02, "R9 live high after latch");

    // R7 toggle then R3 programming clears
    ctlWr(8'h36);
    dataWr(8'h06);
    dataWr(8'h00);
    ticks(3);
    chk(sqOut == 1'b0, "R7 toggled after three ticks", sqOut, 0);
    ctlWr(8'h36);
    chk(sqOut == 1'b1, "R3 sqOut high after program", sqOut, 1);
    rd(8'h00, "R3 count cleared low");
    rd(8'h00, "R3 count cleared high");

    // R4 access 1 and access 2
    ctlWr(8'h16);
    dataWr(8'h08);
    rd(8'h08, "R4 access1 read");
    rd(8'h08, "R4 access1 read again");
    ctlWr(8'h26);
    dataWr(8'h01);
    rd(8'h01, "R4 access2 read");
    rd(8'h01, "R4 access2 read again");

    // R10 non-square mode never counts
    ctlWr(8'h34);
    dataWr(8'h20);
    dataWr(8'h00);
    ticks(5);
    rd(8'h00, "R10 idle low");
    rd(8'h00, "R10 idle high");
    chk(sqOut == 1'b1, "R10 sqOut high", sqOut, 1);

    // R9 latch on the same edge as a wrap
    ctlWr(8'h36);
    dataWr(8'h0A);
    dataWr(8'h00);
    tickEn = 1'b1;
    repeat (4) @(negedge clk);
    wrEn = 1'b1; wrCtl = 1'b1; wrData = 8'h00;
    @(negedge clk);
    wrEn = 1'b0; wrCtl = 1'b0; tickEn = 1'b0;
    chk(sqOut == 1'b0, "R9 wrap with latch toggles", sqOut, 0);
    rd(8'h02, "R9 same-edge latched low");
    rd(8'h00, "R9 same-edge latched high");
    rd(8'h0A, "R9 same-edge live low");
    rd(8'h00, "R9 same-edge live high");

    // R8 reload 1 acts as 65536
    ctlWr(8'h36);
    dataWr(8'h01);
    dataWr(8'h00);
    ticks(1);
    rd(8'hFE, "R8 reload1 low");
    rd(8'hFF, "R8 reload1 high");

    // R7 / R8 periods
    period(16'd10, 10, "R7 period reload 10");
    period(16'd7, 7, "R7 period reload 7");
    period(16'd2, 2, "R7 period reload 2");
    period(16'd0, 65536, "R8 period reload 0");

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R4 all reads answered", expQ.size(), 0);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule